// File: doc/BRIEF.md
# Dual-Channel Hi/Lo PWM Generator

This block drives two independent pulse-width-modulated pins. Each channel counts a programmable number of high ticks and then a programmable number of low ticks. The ticks come from the block clock divided by a per-channel 7-bit prescaler. A per-channel inversion bit flips the pin. A constant-level mode holds the pin steady for 0 % or 100 % duty, so the one-tick phase that a zero count would otherwise produce never appears.

Each channel has two hi/lo pairs: a primary pair and an alternate pair. When the alternate pair is enabled, the channel plays the primary pair for a programmed number of periods and then the alternate pair for its own programmed number of periods, and repeats. A blink mode gates the pin: it alternates one group of running periods with one group of forced-inactive periods for a programmed number of blinks, and then stays quiet until blink mode is re-armed.

Software converts period and duty into counts. It programs the block through a single-cycle register write port with address, data and enable.

Top module: `pwm_dual_hilo`

## Requirements
- R1: A write happens on a rising clock edge while `wrEn` is high. It stores `wrData` into the register selected by `wrAddr`: 0 control, 1 channel A primary duty, 2 channel B primary duty, 3 channel A alternate duty, 4 channel B alternate duty, 5 repeat counts, 6 blink. A write to address 7 changes nothing. Every duty word carries the high count H in bits [31:16] and the low count L in bits [15:0].
- R2: An enabled channel drives its pin high for (H+1)·(P+1) clock cycles and then low for (L+1)·(P+1) cycles, starting with the high phase. The enable is control bit 0 for A and bit 1 for B. P is the prescale field: control bits [14:8] for A and [22:16] for B. The prescaler runs only while the clock-enable bit is set: bit 15 for A, bit 23 for B.
- R3: Control bit 26 (A) and bit 27 (B) invert the channel's pin, so the high phase appears low and the low phase appears high.
- R4: After reset both pins are 0. A channel whose enable bit is clear drives its inactive level, which is the value of its inversion bit.
- R5: With constant mode set (control bit 28 for A, bit 29 for B), the pin stays at one level with no phase changes. Before inversion, that level is high when the active high count is nonzero and low when it is zero.
- R6: New duty values written while a channel runs take effect only at the start of the next period. The high and low phases already under way keep their old lengths.
- R7: Control bit 25 (A) and bit 24 (B) enable the alternate pair. The repeat register holds count−1 fields: A primary [31:24], A alternate [23:16], B primary [15:8], B alternate [7:0]. With the alternate pair enabled, the channel plays the primary pair for (primary field+1) periods, then the alternate pair for (alternate field+1) periods, and repeats. With it disabled, only the primary pair plays.
- R8: Blink enable is blink bit 8 (A) and bit 9 (B), and the blink count−1 sits in bits [3:0] (A) and [7:4] (B). One group is the repeat sequence of R7. While blink is enabled, each blink is one running group followed by one inactive group. After (count+1) blinks the pin stays inactive until blink enable is cleared and set again.
- R9: Clearing a channel's clock-enable bit freezes its pin at its present level.
- R10: The two channels run independently. Settings for one channel never alter the other's pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Register write data |
| pwmOut | output | 2 | PWM pins, bit 0 channel A, bit 1 channel B |

## Verification
A wrong phase counter or prescaler shows up as a wrong run length of the pin, starting in the first period after enable. The bench therefore measures the exact length of each high and low run. Wrong sequencer state (pair select, repeat count, blink phase) shows up within one group: the run lengths come out in the wrong order, or the number of pulses is wrong. A shadow that loads too early shortens or stretches the run in progress at the moment of the write, and that run is the one the bench times.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int N_CH   = 2;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 7;
  localparam int REP_W  = 8;
  localparam int BLK_W  = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_A  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_B  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_A2 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_B2 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_REPEAT  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_BLINK   = 3'd6;

  // sequencing settings consumed by the control side
  typedef struct packed {
    logic             on;
    logic             clkEn;
    logic [PRE_W-1:0] pre;
    logic             set2En;
    logic [REP_W-1:0] times1;
    logic [REP_W-1:0] times2;
    logic             blinkEn;
    logic [BLK_W-1:0] blinkTimes;
  } seqCfg_t;

  // waveform settings consumed by the datapath
  typedef struct packed {
    logic             inv;
    logic             constMode;
    logic [CNT_W-1:0] hi1;
    logic [CNT_W-1:0] lo1;
    logic [CNT_W-1:0] hi2;
    logic [CNT_W-1:0] lo2;
  } waveCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic tick;
    logic useSet2;
  } dpCmd_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output seqCfg_t  [N_CH-1:0]     seqCfg,
  output waveCfg_t [N_CH-1:0]     waveCfg
);
  // fields are stored decoded; bit positions are what software programs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCfg  <= '0;
      waveCfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          seqCfg[0].on         <= wrData[0];
          seqCfg[1].on         <= wrData[1];
          seqCfg[0].pre        <= wrData[8 +: PRE_W];
          seqCfg[0].clkEn      <= wrData[15];
          seqCfg[1].pre        <= wrData[16 +: PRE_W];
          seqCfg[1].clkEn      <= wrData[23];
          seqCfg[1].set2En     <= wrData[24];
          seqCfg[0].set2En     <= wrData[25];
          waveCfg[0].inv       <= wrData[26];
          waveCfg[1].inv       <= wrData[27];
          waveCfg[0].constMode <= wrData[28];
          waveCfg[1].constMode <= wrData[29];
        end
        ADDR_DUTY_A: begin
          waveCfg[0].hi1 <= wrData[DATA_W-1 -: CNT_W];
          waveCfg[0].lo1 <= wrData[CNT_W-1:0];
        end
        ADDR_DUTY_B: begin
          waveCfg[1].hi1 <= wrData[DATA_W-1 -: CNT_W];
          waveCfg[1].lo1 <= wrData[CNT_W-1:0];
        end
        ADDR_DUTY_A2: begin
          waveCfg[0].hi2 <= wrData[DATA_W-1 -: CNT_W];
          waveCfg[0].lo2 <= wrData[CNT_W-1:0];
        end
        ADDR_DUTY_B2: begin
          waveCfg[1].hi2 <= wrData[DATA_W-1 -: CNT_W];
          waveCfg[1].lo2 <= wrData[CNT_W-1:0];
        end
        ADDR_REPEAT: begin
          seqCfg[0].times1 <= wrData[24 +: REP_W];
          seqCfg[0].times2 <= wrData[16 +: REP_W];
          seqCfg[1].times1 <= wrData[8 +: REP_W];
          seqCfg[1].times2 <= wrData[0 +: REP_W];
        end
        ADDR_BLINK: begin
          seqCfg[0].blinkTimes <= wrData[0 +: BLK_W];
          seqCfg[1].blinkTimes <= wrData[4 +: BLK_W];
          seqCfg[0].blinkEn    <= wrData[8];
          seqCfg[1].blinkEn    <= wrData[9];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  seqCfg_t cfg,
  input  logic    periodEnd,
  output dpCmd_t  cmd,
  output logic    gateOff,
  output logic    setSel,
  output logic    blinkDone
);
  logic [PRE_W-1:0] presc;
  logic [REP_W-1:0] repCnt;
  logic [REP_W-1:0] curTimes;
  logic [BLK_W-1:0] blinkCnt;
  logic             blinkOff;
  logic             lastRep;
  logic             nextSet2;
  logic             groupDone;

  always_comb begin
    curTimes    = setSel ? cfg.times2 : cfg.times1;
    lastRep     = (repCnt >= curTimes);
    nextSet2    = cfg.set2En && (lastRep ? !setSel : setSel);
    groupDone   = periodEnd && lastRep && (!cfg.set2En || setSel);
    cmd.clear   = !cfg.on;
    cmd.tick    = cfg.on && cfg.clkEn && (presc >= cfg.pre);
    cmd.useSet2 = nextSet2;
    gateOff     = blinkOff || blinkDone;
  end

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (!cfg.on) begin
      presc <= '0;
    end else if (cfg.clkEn) begin
      presc <= (presc >= cfg.pre) ? '0 : presc + 1'b1;
    end
  end

  // pair select and repeat count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setSel <= 1'b0;
      repCnt <= '0;
    end else if (!cfg.on) begin
      setSel <= 1'b0;
      repCnt <= '0;
    end else if (periodEnd) begin
      setSel <= nextSet2;
      repCnt <= lastRep ? '0 : repCnt + 1'b1;
    end else if (!cfg.set2En) begin
      setSel <= 1'b0;
    end
  end

  // blink sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkOff  <= 1'b0;
      blinkCnt  <= '0;
      blinkDone <= 1'b0;
    end else if (!cfg.on || !cfg.blinkEn) begin
      blinkOff  <= 1'b0;
      blinkCnt  <= '0;
      blinkDone <= 1'b0;
    end else if (groupDone && !blinkDone) begin
      if (!blinkOff) begin
        blinkOff <= 1'b1;
      end else begin
        blinkOff <= 1'b0;
        if (blinkCnt >= cfg.blinkTimes) blinkDone <= 1'b1;
        else                            blinkCnt  <= blinkCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  waveCfg_t         cfg,
  input  dpCmd_t           cmd,
  input  logic             gateOff,
  output logic             pwmOut,
  output logic             periodEnd,
  output logic [CNT_W-1:0] hiShadow
);
  logic             phaseHi;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loShadow;
  logic [CNT_W-1:0] phaseLen;
  logic             phaseDone;
  logic             rawLevel;
  logic             drive;

  always_comb begin
    phaseLen  = phaseHi ? hiShadow : loShadow;
    phaseDone = (cnt >= phaseLen);
    periodEnd = cmd.tick && !phaseHi && phaseDone;
    rawLevel  = cfg.constMode ? (hiShadow != '0) : phaseHi;
    drive     = !cmd.clear && !gateOff && rawLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHi  <= 1'b1;
      cnt      <= '0;
      hiShadow <= '0;
      loShadow <= '0;
      pwmOut   <= 1'b0;
    end else begin
      pwmOut <= cfg.inv ^ drive;
      if (cmd.clear) begin
        phaseHi  <= 1'b1;
        cnt      <= '0;
        hiShadow <= cfg.hi1;
        loShadow <= cfg.lo1;
      end else if (cmd.tick) begin
        if (phaseDone) begin
          cnt     <= '0;
          phaseHi <= !phaseHi;
          if (!phaseHi) begin
            hiShadow <= cmd.useSet2 ? cfg.hi2 : cfg.hi1;
            loShadow <= cmd.useSet2 ? cfg.lo2 : cfg.lo1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_dual_hilo.sv
module pwm_dual_hilo
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [N_CH-1:0]   pwmOut
);
  seqCfg_t  [N_CH-1:0]            seqCfg;
  waveCfg_t [N_CH-1:0]            waveCfg;
  logic     [N_CH-1:0]            chanOn;
  logic     [N_CH-1:0]            chanInv;
  logic     [N_CH-1:0]            chanSet2;
  logic     [N_CH-1:0]            setSel;
  logic     [N_CH-1:0]            blinkDone;
  logic     [N_CH-1:0]            periodEnd;
  logic     [N_CH-1:0][CNT_W-1:0] hiShadow;

  pwm_cfg_regs regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .seqCfg(seqCfg), .waveCfg(waveCfg)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    dpCmd_t cmd;
    logic   gateOff;

    assign chanOn[ch]   = seqCfg[ch].on;
    assign chanInv[ch]  = waveCfg[ch].inv;
    assign chanSet2[ch] = seqCfg[ch].set2En;

    pwm_chan_ctrl ctrl_i (
      .clk(clk), .rstN(rstN), .cfg(seqCfg[ch]), .periodEnd(periodEnd[ch]),
      .cmd(cmd), .gateOff(gateOff), .setSel(setSel[ch]), .blinkDone(blinkDone[ch])
    );

    pwm_chan_dp dp_i (
      .clk(clk), .rstN(rstN), .cfg(waveCfg[ch]), .cmd(cmd), .gateOff(gateOff),
      .pwmOut(pwmOut[ch]), .periodEnd(periodEnd[ch]), .hiShadow(hiShadow[ch])
    );
  end
endmodule

// File: rtl/pwm_dual_hilo_chk.sv
module pwm_dual_hilo_chk
  import pwm_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [N_CH-1:0]            ctrlEnBits,
  input logic [N_CH-1:0]            pwmOut,
  input logic [N_CH-1:0]            chanOn,
  input logic [N_CH-1:0]            chanInv,
  input logic [N_CH-1:0]            chanSet2,
  input logic [N_CH-1:0]            setSel,
  input logic [N_CH-1:0]            blinkDone,
  input logic [N_CH-1:0]            periodEnd,
  input logic [N_CH-1:0][CNT_W-1:0] hiShadow
);
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL) |=> (chanOn == $past(ctrlEnBits))); // R1

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      !chanOn[ch] |=> (pwmOut[ch] == $past(chanInv[ch]))); // R4

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (chanOn[ch] && $past(chanOn[ch]) && !$past(periodEnd[ch])) |-> $stable(hiShadow[ch])); // R6

    AST_PRIMARY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      (chanOn[ch] && !chanSet2[ch]) |=> !setSel[ch]); // R7

    AST_BLINK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      blinkDone[ch] |=> (pwmOut[ch] == $past(chanInv[ch]))); // R8
  end
endmodule

bind pwm_dual_hilo pwm_dual_hilo_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .ctrlEnBits(wrData[1:0]),
  .pwmOut(pwmOut), .chanOn(chanOn), .chanInv(chanInv), .chanSet2(chanSet2),
  .setSel(setSel), .blinkDone(blinkDone), .periodEnd(periodEnd), .hiShadow(hiShadow)
);

// File: tb/pwm_dual_hilo_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_hilo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  pwmOut;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  pwm_dual_hilo dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                       .wrData(wrData), .pwmOut(pwmOut));

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(int addr, logic [31:0] d);
    wrEn = 1'b1; wrAddr = addr[2:0]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(bit enA, bit enB, int preA, int preB,
      bit invA = 0, bit invB = 0, bit constA = 0, bit constB = 0,
      bit altA = 0, bit altB = 0, bit clkA = 1, bit clkB = 1);
    logic [31:0] w = '0;
    w[0] = enA;  w[1] = enB;
    w[14:8] = preA[6:0];  w[15] = clkA;
    w[22:16] = preB[6:0]; w[23] = clkB;
    w[24] = altB; w[25] = altA; w[26] = invA; w[27] = invB;
    w[28] = constA; w[29] = constB;
    return w;
  endfunction

  function automatic logic [31:0] duty(int h, int l);
    return {h[15:0], l[15:0]};
  endfunction

  task automatic waitRise(int ch, output bit ok);
    logic prev = pwmOut[ch];
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) begin ok = 1; return; end
      prev = pwmOut[ch];
    end
  endtask

  task automatic runLen(int ch, logic lvl, int n0, output int n);
    n = n0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (pwmOut[ch] !== lvl) return;
      n++;
    end
  endtask

  task automatic countRises(int ch, int cycles, output int n);
    logic prev = pwmOut[ch];
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) n++;
      prev = pwmOut[ch];
    end
  endtask

  task automatic steadyMiss(int ch, logic lvl, int cycles, output int miss);
    miss = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pwmOut[ch] !== lvl) miss++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    bit ok;
    int hi, lo, n, miss, p, h, l;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R4 reset level", int'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 after reset", int'(pwmOut), 0);

    // R4: disabled channels drive the inversion bit
    wr(0, ctrlWord(0, 0, 0, 0, 1, 1));
    @(negedge clk);
    steadyMiss(0, 1'b1, 20, miss); check("R4 idle A inverted", miss, 0);
    steadyMiss(1, 1'b1, 5, miss);  check("R4 idle B inverted", miss, 0);

    // R2: random hi/lo/prescale on channel A
    for (int it = 0; it < 6; it++) begin
      p = $urandom_range(3, 0); h = $urandom_range(7, 0); l = $urandom_range(7, 0);
      wr(0, 32'h0); wr(1, duty(h, l)); wr(0, ctrlWord(1, 0, p, 0));
      waitRise(0, ok); check("R2 start", int'(ok), 1);
      runLen(0, 1'b1, 1, hi); runLen(0, 1'b0, 1, lo);
      check("R2 high run", hi, (h + 1) * (p + 1));
      check("R2 low run", lo, (l + 1) * (p + 1));
    end

    // R10: channel B with its own fields while A is off
    for (int it = 0; it < 4; it++) begin
      p = $urandom_range(3, 0); h = $urandom_range(7, 0); l = $urandom_range(7, 0);
      wr(0, 32'h0); wr(2, duty(h, l)); wr(0, ctrlWord(0, 1, 0, p));
      waitRise(1, ok); check("R10 B start", int'(ok), 1);
      runLen(1, 1'b1, 1, hi); runLen(1, 1'b0, 1, lo);
      check("R10 B high run", hi, (h + 1) * (p + 1));
      check("R10 B low run", lo, (l + 1) * (p + 1));
      check("R10 A untouched", int'(pwmOut[0]), 0);
    end

    // R3: inversion swaps the phases on the pin
    p = 1; h = 2; l = 5;
    wr(0, ctrlWord(0, 0, 0, 0, 1, 0)); wr(1, duty(h, l));
    wr(0, ctrlWord(1, 0, p, 0, 1, 0));
    waitRise(0, ok); check("R3 start", int'(ok), 1);
    runLen(0, 1'b1, 1, hi); runLen(0, 1'b0, 1, lo);
    check("R3 inverted high run", hi, (l + 1) * (p + 1));
    check("R3 inverted low run", lo, (h + 1) * (p + 1));

    // R5: constant mode
    wr(0, 32'h0); wr(1, duty(5, 0)); wr(0, ctrlWord(1, 0, 0, 0, 0, 0, 1, 0));
    @(negedge clk); @(negedge clk);
    steadyMiss(0, 1'b1, 60, miss); check("R5 steady high", miss, 0);
    wr(0, 32'h0); wr(1, duty(0, 5)); wr(0, ctrlWord(1, 0, 0, 0, 1, 0, 1, 0));
    @(negedge clk); @(negedge clk);
    steadyMiss(0, 1'b1, 60, miss); check("R5 steady inverted low", miss, 0);

    // R6: a duty write during a period waits for the boundary
    wr(0, 32'h0); wr(1, duty(5, 3)); wr(0, ctrlWord(1, 0, 0, 0));
    waitRise(0, ok); check("R6 start", int'(ok), 1);
    wr(1, duty(9, 3));
    runLen(0, 1'b1, 2, hi); check("R6 current high keeps old", hi, 6);
    runLen(0, 1'b0, 1, lo); check("R6 current low keeps old", lo, 4);
    runLen(0, 1'b1, 1, hi); check("R6 next high uses new", hi, 10);

    // R1: unused address leaves the running channel alone
    wr(7, 32'hFFFF_FFFF);
    waitRise(0, ok);
    runLen(0, 1'b1, 1, hi); runLen(0, 1'b0, 1, lo);
    check("R1 addr 7 ignored high", hi, 10);
    check("R1 addr 7 ignored low", lo, 4);

    // R7: primary x2, alternate x1
    wr(0, 32'h0); wr(1, duty(1, 1)); wr(3, duty(4, 1)); wr(5, 32'h0100_0000);
    wr(0, ctrlWord(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    waitRise(0, ok); check("R7 start", int'(ok), 1);
    for (int k = 0; k < 6; k++) begin
      runLen(0, 1'b1, 1, hi); runLen(0, 1'b0, 1, lo);
      check("R7 pair order", hi, (k % 3 == 2) ? 5 : 2);
    end

    // R8: two blinks, then quiet, then re-arm
    wr(0, 32'h0); wr(5, 32'h0); wr(6, 32'h0000_0101);
    wr(0, ctrlWord(1, 0, 0, 0));
    countRises(0, 300, n); check("R8 blink pulses", n, 2);
    steadyMiss(0, 1'b0, 50, miss); check("R8 quiet after blinks", miss, 0);
    wr(6, 32'h0); wr(6, 32'h0000_0101);
    countRises(0, 300, n); check("R8 re-armed pulses", int'(n >= 1 && n <= 3), 1);
    wr(6, 32'h0);

    // R9: clock enable cleared freezes the pin
    wr(0, 32'h0); wr(1, duty(7, 7)); wr(0, ctrlWord(1, 0, 1, 0));
    waitRise(0, ok); check("R9 start", int'(ok), 1);
    wr(0, ctrlWord(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    steadyMiss(0, 1'b1, 200, miss); check("R9 frozen", miss, 0);

    // R10: both channels at once with different settings
    wr(0, 32'h0); wr(1, duty(2, 2)); wr(2, duty(6, 1));
    wr(0, ctrlWord(1, 1, 0, 1));
    waitRise(1, ok);
    runLen(1, 1'b1, 1, hi); check("R10 B high beside A", hi, 14);
    waitRise(0, ok);
    runLen(0, 1'b1, 1, hi); check("R10 A high beside B", hi, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule